// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches three 8-pin general-purpose input ports (A, B and F) and turns pin activity into interrupt requests. Each pin can be set to trigger on a level (high or low) or on an edge (rising or falling). Software sets the mode through byte-wide registers on a simple register bus. Every input passes through a two-flop synchroniser. A per-pin debounce filter can also be switched in, and it only passes a change once the input has held its new value for `DB_CYCLES` clocks.

A detected edge is held in a per-pin latch until software writes a one to that pin's bit in the port's acknowledge register. In level mode there is no latch, and the pin's status simply follows the pin. Ports A and B together drive one combined interrupt line. Port F drives one interrupt line per pin. To reconfigure a pin, software clears its enable bit, changes the mode bits and then enables the pin again. While the enable bit is clear, the pin can never raise an interrupt.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_ab` is low and `irq_f` is all zeros.
- R2: The configuration registers are written and read back at these offsets, listed as mode / polarity / enable / debounce. Port A: 0x90 / 0x94 / 0x9C / 0xA8. Port B: 0xAC / 0xB0 / 0xB8 / 0xC4. Port F: 0x4C / 0x50 / 0x58 / 0x64. The read-only status registers are at 0xA0 (A), 0xBC (B) and 0x5C (F). Any other offset reads 0.
- R3: A pin whose mode bit is 0 is level-triggered. Its status bit is 1 exactly while the filtered pin equals its polarity bit (1 = high active, 0 = low active).
- R4: A pin whose mode bit is 1 is edge-triggered. A transition in the direction given by the polarity bit (1 = rising, 0 = falling) sets the pin's status. The status stays set until it is acknowledged, and a transition in the other direction does not set it.
- R5: The acknowledge registers are at 0x98 (A), 0xB4 (B) and 0x54 (F). Writing a 1 to bit i clears only pin i's latched edge. Bits written as 0 have no effect. These registers read as 0.
- R6: A pin with its enable bit at 0 reports status 0. Changing mode or polarity while the pin is disabled never raises an interrupt. Clearing the enable bit discards any latched edge.
- R7: `irq_ab` is the OR of all port A and port B status bits. `irq_f[i]` equals port F status bit i.
- R8: With its debounce bit set, a pin ignores pulses shorter than `DB_CYCLES` clocks and passes changes that last longer. With the bit clear, a 2-clock pulse is enough to trigger an edge.
- R9: Without debounce, a pin change shows up in level-mode status on the second rising clock edge after the change, and not on the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Combinational read data for `bus_addr` |
| pin_a | input | PORT_W | Port A input pins, asynchronous |
| pin_b | input | PORT_W | Port B input pins, asynchronous |
| pin_f | input | PORT_W | Port F input pins, asynchronous |
| irq_ab | output | 1 | Combined interrupt for ports A and B |
| irq_f | output | PORT_W | Per-pin interrupts for port F |

## Verification
The hardest cases to reach are edges that arrive around configuration changes. Examples are an edge latched before its enable bit is cleared, or a pin already at its active level when the mode bits are rewritten. The bench sweeps every port, every pin and all four mode/polarity combinations. Each iteration programs the pin while it is disabled, enables it, and drives the pin up and back down. It then acknowledges the other pins before the pin under test, so the expected latch state is known at every step. Separate sequences time a glitch against the debounce window and test the two-edge synchroniser latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int NPORT = 3;

    // Index 0 = port A, 1 = port B, 2 = port F.
    localparam logic [7:0] OFS_MODE [NPORT] = '{8'h90, 8'hAC, 8'h4C};
    localparam logic [7:0] OFS_POL  [NPORT] = '{8'h94, 8'hB0, 8'h50};
    localparam logic [7:0] OFS_ACK  [NPORT] = '{8'h98, 8'hB4, 8'h54};
    localparam logic [7:0] OFS_EN   [NPORT] = '{8'h9C, 8'hB8, 8'h58};
    localparam logic [7:0] OFS_STAT [NPORT] = '{8'hA0, 8'hBC, 8'h5C};
    localparam logic [7:0] OFS_DB   [NPORT] = '{8'hA8, 8'hC4, 8'h64};

    typedef struct packed {
        logic mode;
        logic pol;
        logic ack;
        logic en;
        logic db;
    } port_wr_t;
endpackage

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
    parameter int W         = 8,
    parameter int DB_CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] db_sel,
    output logic [W-1:0] pin_o
);
    localparam int CW = $clog2(DB_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DB_CYCLES - 1);

    typedef struct packed {
        logic [W-1:0]         s1;
        logic [W-1:0]         s2;
        logic [W-1:0]         deb;
        logic [W-1:0][CW-1:0] cnt;
    } filt_t;

    filt_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        for (int k = 0; k < W; k++) begin
            if (st_q.s2[k] == st_q.deb[k]) begin
                st_d.cnt[k] = '0;
            end else if (st_q.cnt[k] == CNT_LAST) begin
                st_d.deb[k] = st_q.s2[k];
                st_d.cnt[k] = '0;
            end else begin
                st_d.cnt[k] = st_q.cnt[k] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o = (db_sel & st_q.deb) | (~db_sel & st_q.s2);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int W         = 8,
    parameter int DB_CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  port_wr_t     wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] db_o,
    output logic [W-1:0] status_o
);
    typedef struct packed {
        logic [W-1:0] mode;
        logic [W-1:0] pol;
        logic [W-1:0] en;
        logic [W-1:0] db;
        logic [W-1:0] prev;
        logic [W-1:0] lat;
    } port_st_t;

    port_st_t st_q, st_d;
    logic [W-1:0] pin_f;
    logic [W-1:0] edge_hit;
    logic [W-1:0] ack_mask;

    gpio_irq_filter #(.W(W), .DB_CYCLES(DB_CYCLES)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .db_sel (st_q.db),
        .pin_o  (pin_f)
    );

    always_comb begin
        st_d      = st_q;
        edge_hit  = (pin_f & ~st_q.prev & st_q.pol) | (~pin_f & st_q.prev & ~st_q.pol);
        ack_mask  = wr.ack ? wdata : '0;
        if (wr.mode) st_d.mode = wdata;
        if (wr.pol)  st_d.pol  = wdata;
        if (wr.en)   st_d.en   = wdata;
        if (wr.db)   st_d.db   = wdata;
        st_d.prev = pin_f;
        st_d.lat  = st_q.en & st_q.mode & ((st_q.lat & ~ack_mask) | edge_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign pol_o    = st_q.pol;
    assign en_o     = st_q.en;
    assign db_o     = st_q.db;
    assign status_o = st_q.en & ((st_q.mode & st_q.lat) |
                                 (~st_q.mode & ~(pin_f ^ st_q.pol)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int DB_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_a,
    input  logic [PORT_W-1:0] pin_b,
    input  logic [PORT_W-1:0] pin_f,
    output logic              irq_ab,
    output logic [PORT_W-1:0] irq_f
);
    logic [NPORT-1:0][PORT_W-1:0] pins;
    logic [NPORT-1:0][PORT_W-1:0] port_status;
    logic [NPORT-1:0][PORT_W-1:0] port_mode;
    logic [NPORT-1:0][PORT_W-1:0] port_pol;
    logic [NPORT-1:0][PORT_W-1:0] port_en;
    logic [NPORT-1:0][PORT_W-1:0] port_db;

    assign pins[0] = pin_a;
    assign pins[1] = pin_b;
    assign pins[2] = pin_f;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_wr_t wr;
        assign wr.mode = bus_wr && (bus_addr == OFS_MODE[p]);
        assign wr.pol  = bus_wr && (bus_addr == OFS_POL[p]);
        assign wr.ack  = bus_wr && (bus_addr == OFS_ACK[p]);
        assign wr.en   = bus_wr && (bus_addr == OFS_EN[p]);
        assign wr.db   = bus_wr && (bus_addr == OFS_DB[p]);

        gpio_irq_port #(.W(PORT_W), .DB_CYCLES(DB_CYCLES)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pins[p]),
            .wr       (wr),
            .wdata    (bus_wdata),
            .mode_o   (port_mode[p]),
            .pol_o    (port_pol[p]),
            .en_o     (port_en[p]),
            .db_o     (port_db[p]),
            .status_o (port_status[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (bus_addr == OFS_MODE[p]) bus_rdata = port_mode[p];
            if (bus_addr == OFS_POL[p])  bus_rdata = port_pol[p];
            if (bus_addr == OFS_EN[p])   bus_rdata = port_en[p];
            if (bus_addr == OFS_DB[p])   bus_rdata = port_db[p];
            if (bus_addr == OFS_STAT[p]) bus_rdata = port_status[p];
        end
    end

    assign irq_ab = (|port_status[0]) | (|port_status[1]);
    assign irq_f  = port_status[2];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [7:0]                   bus_addr,
    input logic                         bus_wr,
    input logic [PORT_W-1:0]            bus_wdata,
    input logic                         irq_ab,
    input logic [PORT_W-1:0]            irq_f,
    input logic [NPORT-1:0][PORT_W-1:0] port_status,
    input logic [NPORT-1:0][PORT_W-1:0] port_mode
);
    // R6: writing an all-zero enable to port A silences it on the next cycle.
    p_disable_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN[0] && bus_wdata == '0) |=> (port_status[0] == '0));

    // R7: port F interrupt lines never exceed the enable value just written.
    p_f_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN[2]) |=> ((irq_f & ~$past(bus_wdata)) == '0));

    // R7: the combined line stays low while ports A and B show no status.
    p_ab_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_status[0] == '0 && port_status[1] == '0) |-> !irq_ab);

    // R4: with no bus write, a latched edge on port B cannot disappear.
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (($past(port_status[1]) & $past(port_mode[1]) & ~port_status[1]) == '0));

    // R4: the same for port F.
    p_edge_hold_f_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (($past(irq_f) & $past(port_mode[2]) & ~irq_f) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    import gpio_irq_pkg::*;

    localparam int W  = 8;
    localparam int DB = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [2:0][W-1:0] drv = '0;
    logic         irq_ab;
    logic [W-1:0] irq_f;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.PORT_W(W), .DB_CYCLES(DB)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_a     (drv[0]),
        .pin_b     (drv[1]),
        .pin_f     (drv[2]),
        .irq_ab    (irq_ab),
        .irq_f     (irq_f)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare the status of port p and its interrupt output with exp on pin i only.
    task automatic chk_port(string req, int p, int i, bit exp);
        logic [W-1:0] v;
        rd(OFS_STAT[p], v);
        chk(req, v, W'(exp) << i);
        if (p < 2) chk({req, " irq_ab"}, W'(irq_ab), W'(exp));
        else       chk({req, " irq_f"}, irq_f, W'(exp) << i);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [7:0]   regs [5];

        // R1: reset state
        idle(2);
        for (int p = 0; p < NPORT; p++) begin
            regs = '{OFS_MODE[p], OFS_POL[p], OFS_EN[p], OFS_DB[p], OFS_STAT[p]};
            for (int r = 0; r < 5; r++) begin
                rd(regs[r], v);
                chk("R1 reset read", v, '0);
            end
        end
        chk("R1 irq_ab", W'(irq_ab), '0);
        chk("R1 irq_f", irq_f, '0);
        rst_n = 1'b1;
        idle(2);

        // R2: register readback, R5: acknowledge reads zero
        for (int p = 0; p < NPORT; p++) begin
            regs = '{OFS_MODE[p], OFS_POL[p], OFS_EN[p], OFS_DB[p], OFS_ACK[p]};
            for (int r = 0; r < 5; r++) wr(regs[r], 8'h5A ^ 8'((p << 4) + r + 1));
            for (int r = 0; r < 4; r++) begin
                rd(regs[r], v);
                chk("R2 readback", v, 8'h5A ^ 8'((p << 4) + r + 1));
            end
            rd(OFS_ACK[p], v);
            chk("R5 ack reads zero", v, '0);
            for (int r = 0; r < 4; r++) wr(regs[r], '0);
            wr(OFS_ACK[p], '1);
        end
        rd(8'h00, v);
        chk("R2 unmapped", v, '0);

        // R3/R4/R5/R6/R7: sweep every port, pin and mode
        for (int p = 0; p < NPORT; p++) begin
            for (int i = 0; i < W; i++) begin
                for (int m = 0; m < 4; m++) begin
                    bit is_edge = m[1];
                    bit pol = m[0];
                    bit lat = 0;
                    wr(OFS_EN[p], '0);
                    drv[p] = '0;
                    idle(4);
                    wr(OFS_MODE[p], W'(is_edge) << i);
                    wr(OFS_POL[p], W'(pol) << i);
                    wr(OFS_ACK[p], '1);
                    chk_port("R6 config while disabled", p, i, 1'b0);
                    wr(OFS_EN[p], W'(1) << i);
                    idle(2);
                    chk_port(is_edge ? "R4 idle" : "R3 low pin", p, i, is_edge ? 1'b0 : !pol);
                    drv[p][i] = 1'b1;
                    idle(4);
                    if (is_edge && pol) lat = 1;
                    chk_port(is_edge ? "R4 rise" : "R3 high pin", p, i, is_edge ? lat : pol);
                    drv[p][i] = 1'b0;
                    idle(4);
                    if (is_edge && !pol) lat = 1;
                    chk_port(is_edge ? "R4 fall" : "R3 low again", p, i, is_edge ? lat : !pol);
                    wr(OFS_ACK[p], ~(W'(1) << i));
                    chk_port("R5 other bits ack", p, i, is_edge ? lat : !pol);
                    wr(OFS_ACK[p], W'(1) << i);
                    chk_port("R5 own bit ack", p, i, is_edge ? 1'b0 : !pol);
                    wr(OFS_EN[p], '0);
                    chk_port("R6 disabled", p, i, 1'b0);
                end
            end
        end

        // R6: a latched edge is discarded by clearing enable
        wr(OFS_MODE[1], 8'h04);
        wr(OFS_POL[1], 8'h04);
        wr(OFS_EN[1], 8'h04);
        drv[1][2] = 1'b1;
        idle(4);
        chk_port("R6 latched before disable", 1, 2, 1'b1);
        wr(OFS_EN[1], '0);
        idle(1);
        wr(OFS_EN[1], 8'h04);
        chk_port("R6 latch discarded", 1, 2, 1'b0);
        wr(OFS_EN[1], '0);
        drv[1] = '0;

        // R7: both A and B active, then one acknowledged
        wr(OFS_MODE[0], 8'h01); wr(OFS_POL[0], 8'h01);
        wr(OFS_MODE[1], 8'h80); wr(OFS_POL[1], 8'h80);
        wr(OFS_EN[0], 8'h01);   wr(OFS_EN[1], 8'h80);
        drv[0][0] = 1'b1; drv[1][7] = 1'b1;
        idle(4);
        chk("R7 both", W'(irq_ab), 1);
        wr(OFS_ACK[0], 8'h01);
        chk("R7 B still holds", W'(irq_ab), 1);
        wr(OFS_ACK[1], 8'h80);
        chk("R7 both acked", W'(irq_ab), 0);
        wr(OFS_EN[0], '0); wr(OFS_EN[1], '0);
        drv = '0;
        idle(4);

        // R8: debounce on port A pin 3, rising edge
        wr(OFS_DB[0], 8'h08);
        wr(OFS_MODE[0], 8'h08);
        wr(OFS_POL[0], 8'h08);
        wr(OFS_ACK[0], '1);
        wr(OFS_EN[0], 8'h08);
        idle(DB + 4);
        drv[0][3] = 1'b1;
        idle(DB / 2);
        drv[0][3] = 1'b0;
        idle(3 * DB);
        chk_port("R8 glitch rejected", 0, 3, 1'b0);
        drv[0][3] = 1'b1;
        idle(3 * DB);
        chk_port("R8 held change passes", 0, 3, 1'b1);
        wr(OFS_EN[0], '0);
        wr(OFS_DB[0], '0);
        drv = '0;
        idle(4);
        // R8: short pulse without debounce
        wr(OFS_ACK[0], '1);
        wr(OFS_EN[0], 8'h08);
        drv[0][3] = 1'b1;
        idle(2);
        drv[0][3] = 1'b0;
        idle(4);
        chk_port("R8 short pulse undebounced", 0, 3, 1'b1);
        wr(OFS_EN[0], '0);

        // R9: synchroniser latency, level-high on port F pin 0
        wr(OFS_MODE[2], '0);
        wr(OFS_POL[2], 8'h01);
        wr(OFS_EN[2], 8'h01);
        idle(3);
        chk("R9 before", irq_f, '0);
        drv[2][0] = 1'b1;
        @(negedge clk);
        chk("R9 after one edge", irq_f, '0);
        @(negedge clk);
        chk("R9 after two edges", irq_f, 8'h01);
        wr(OFS_EN[2], '0);
        drv = '0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule